// File: doc/BRIEF.md
# Dual-Issue Pair Check

This block sits at the decode stage of an in-order, two-wide pipeline. Each cycle it looks at the pair of predecoded instructions held in the pair buffer and decides how many of them leave. The answer can be none, the older one alone, or both. The decision uses three inputs: a per-slot ready flag from the hazard unit, which covers RAW hazards against older in-flight work; the pairing legality of the two instructions; and whether the older one already left in an earlier cycle.

Each instruction arrives as a packed descriptor. It carries:
- an instruction class;
- a register-format bit;
- a microcoded flag and a jump flag;
- a destination-write flag;
- one destination and two source register numbers.

When only the older instruction of a pair issues, the pair stays in the buffer. The younger one then issues alone as soon as it is ready. The block raises `accept_o` in the cycle the last instruction of the pair leaves, and the buffer loads the next pair on that clock edge. `hold_o` tells the buffer to keep its contents.

Top module: `dual_issue_pairer`

## Requirements
- R1: While `rst` is high, `issue0_o`, `issue1_o`, `accept_o` and `hold_o` are all low. Any partially issued pair is forgotten, so the first pair after reset is treated as fresh.
- R2: For a fresh pair with `pair_vld_i` high, slot 0 issues exactly when `rdy0_i` is high.
- R3: Slot 1 never issues unless slot 0 issues in the same cycle or already issued earlier. If the older instruction stalls, the younger one stalls too.
- R4: Suppose slot 0 issues but slot 1 does not. In every later cycle, slot 0 stays quiet and `hold_o` stays high until slot 1 issues alone. Slot 1 issues alone in the first cycle that `rdy1_i` is high.
- R5: `accept_o` is high exactly in the cycle the last outstanding instruction of the pair issues. `hold_o` equals `pair_vld_i` and not `accept_o`.
- R6: Descriptor layout for a register width W:
  - bits [2:0] hold the class: 0 integer operate, 1 floating operate, 2 load, 3 store, 4 branch, codes 5 to 7 undefined;
  - bit 3 is the format (1 = floating);
  - bit 4 is the microcoded flag;
  - bit 5 is the jump flag;
  - bit 6 is the write flag;
  - then come the destination, source A and source B, each W bits wide.

  Two memory instructions (load or store) never pair. Two floating operates never pair. An undefined class never pairs.
- R7: A load pairs with an operate of either format. A store pairs with an operate only when the store's format matches the operate's format; a mismatch is blocked because the two share a result bus.
- R8: An integer operate pairs with a floating operate in either order.
- R9: A branch pairs with a load, with an operate, and with a store of the other format. A branch never pairs with a store of its own format.
- R10: Integer operates and branches both use the integer pipes. When both instructions use them, the pair is legal only if all of the following hold:
  - neither instruction is microcoded;
  - the older one has no jump flag;
  - there is no WAW conflict, meaning both write the same destination;
  - there is no WAR conflict, meaning the younger instruction writes a source of the older one.

  A RAW dependence from older to younger is not a pairing rule.
- R11: With `pair_vld_i` low, nothing issues, `accept_o` and `hold_o` are low, and a partially issued pair stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_vld_i | input | 1 | Pair buffer holds a pair |
| desc0_i | input | DESC_W | Older instruction descriptor |
| desc1_i | input | DESC_W | Younger instruction descriptor |
| rdy0_i | input | 1 | Older instruction free of RAW hazards |
| rdy1_i | input | 1 | Younger instruction free of RAW hazards |
| issue0_o | output | 1 | Older instruction issues this cycle |
| issue1_o | output | 1 | Younger instruction issues this cycle |
| accept_o | output | 1 | Pair finished; load next pair at this edge |
| hold_o | output | 1 | Keep the pair buffer contents |

## Verification
The bench targets the format-sensitive rules: a store with an operate of the other format, a store with an operate of the same format, and a branch with a store of its own or the other format. A design that ignores the shared result bus would issue both instructions of a mismatched pair at once. It also covers a partially issued pair across ready and not-ready cycles and across an empty-buffer cycle. A design that re-issues slot 0 or drops the pending state would show a second `issue0_o` or an early `accept_o`. The integer-pipe cases separate WAR and WAW conflicts, which must block, from a RAW dependence and a jump in the younger slot, which must not. A design that compared the wrong register fields would pair or split these wrongly.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  localparam int CLS_W  = 3;
  localparam int FLAG_W = 4;
  localparam int HDR_W  = CLS_W + FLAG_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_IOP = 3'd0,
    CLS_FOP = 3'd1,
    CLS_LD  = 3'd2,
    CLS_ST  = 3'd3,
    CLS_BR  = 3'd4
  } cls_e;

  typedef struct packed {
    logic iop;
    logic fop;
    logic ld;
    logic st;
    logic br;
    logic mem;
    logic ipipe;
    logic bad;
    logic fpf;
    logic ucode;
    logic jump;
    logic wr;
  } dec_t;

endpackage

// File: rtl/desc_decode.sv
module desc_decode
  import dual_issue_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int DESC_W = HDR_W + 3 * REG_W
) (
  input  logic [DESC_W-1:0] desc_i,
  output dec_t              dec_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rsa_o,
  output logic [REG_W-1:0]  rsb_o
);

  logic [CLS_W-1:0] cls;

  assign cls   = desc_i[CLS_W-1:0];
  assign rd_o  = desc_i[HDR_W +: REG_W];
  assign rsa_o = desc_i[HDR_W + REG_W +: REG_W];
  assign rsb_o = desc_i[HDR_W + 2*REG_W +: REG_W];

  always_comb begin
    dec_o       = '0;
    dec_o.fpf   = desc_i[CLS_W];
    dec_o.ucode = desc_i[CLS_W+1];
    dec_o.jump  = desc_i[CLS_W+2];
    dec_o.wr    = desc_i[CLS_W+3];
    case (cls)
      CLS_IOP: dec_o.iop = 1'b1;
      CLS_FOP: dec_o.fop = 1'b1;
      CLS_LD:  dec_o.ld  = 1'b1;
      CLS_ST:  dec_o.st  = 1'b1;
      CLS_BR:  dec_o.br  = 1'b1;
      default: dec_o.bad = 1'b1;
    endcase
    dec_o.mem   = dec_o.ld | dec_o.st;
    dec_o.ipipe = dec_o.iop | dec_o.br;
  end

endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import dual_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  dec_t             d0_i,
  input  dec_t             d1_i,
  input  logic [REG_W-1:0] rd0_i,
  input  logic [REG_W-1:0] rsa0_i,
  input  logic [REG_W-1:0] rsb0_i,
  input  logic [REG_W-1:0] rd1_i,
  output logic             pair_ok_o
);

  logic unit_clash;
  logic bus_clash;
  logic br_st_clash;
  logic waw;
  logic war;
  logic int_clash;
  logic op0;
  logic op1;

  assign op0 = d0_i.iop | d0_i.fop;
  assign op1 = d1_i.iop | d1_i.fop;

  // Same functional unit, or an undecodable class.
  assign unit_clash = (d0_i.mem & d1_i.mem) | (d0_i.fop & d1_i.fop) |
                      d0_i.bad | d1_i.bad;

  // A store shares its result bus with operates of its own format only.
  assign bus_clash = (d0_i.st & op1 & (d0_i.fpf != d1_i.fop)) |
                     (d1_i.st & op0 & (d1_i.fpf != d0_i.fop));

  assign br_st_clash = (d0_i.br & d1_i.st & (d0_i.fpf == d1_i.fpf)) |
                       (d1_i.br & d0_i.st & (d1_i.fpf == d0_i.fpf));

  assign waw = d0_i.wr & d1_i.wr & (rd0_i == rd1_i);
  assign war = d1_i.wr & ((rd1_i == rsa0_i) | (rd1_i == rsb0_i));

  assign int_clash = d0_i.ipipe & d1_i.ipipe &
                     (d0_i.ucode | d1_i.ucode | d0_i.jump | waw | war);

  assign pair_ok_o = ~(unit_clash | bus_clash | br_st_clash | int_clash);

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  logic rdy0_i,
  input  logic rdy1_i,
  input  logic pair_ok_i,
  output logic iss0_o,
  output logic iss1_o,
  output logic accept_o,
  output logic hold_o
);

  // Set while the older slot has gone and the younger is still waiting.
  logic owed_q;

  always_comb begin
    iss0_o   = 1'b0;
    iss1_o   = 1'b0;
    accept_o = 1'b0;
    if (!rst && vld_i) begin
      if (owed_q) begin
        iss1_o   = rdy1_i;
        accept_o = rdy1_i;
      end else begin
        iss0_o   = rdy0_i;
        iss1_o   = rdy0_i & rdy1_i & pair_ok_i;
        accept_o = rdy0_i & rdy1_i & pair_ok_i;
      end
    end
    hold_o = !rst && vld_i && !accept_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= 1'b0;
    end else if (vld_i) begin
      if (owed_q) begin
        if (rdy1_i) owed_q <= 1'b0;
      end else if (iss0_o && !iss1_o) begin
        owed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dual_issue_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int DESC_W = HDR_W + 3 * REG_W,
  localparam int SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_vld_i,
  input  logic [DESC_W-1:0] desc0_i,
  input  logic [DESC_W-1:0] desc1_i,
  input  logic              rdy0_i,
  input  logic              rdy1_i,
  output logic              issue0_o,
  output logic              issue1_o,
  output logic              accept_o,
  output logic              hold_o
);

  logic [DESC_W-1:0] desc [SLOTS];
  dec_t              dec  [SLOTS];
  logic [REG_W-1:0]  rd   [SLOTS];
  logic [REG_W-1:0]  rsa  [SLOTS];
  logic [REG_W-1:0]  rsb  [SLOTS];
  logic              pair_ok;

  assign desc[0] = desc0_i;
  assign desc[1] = desc1_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    desc_decode #(.REG_W(REG_W)) dec_i (
      .desc_i (desc[s]),
      .dec_o  (dec[s]),
      .rd_o   (rd[s]),
      .rsa_o  (rsa[s]),
      .rsb_o  (rsb[s])
    );
  end

  pair_rules #(.REG_W(REG_W)) rules_i (
    .d0_i      (dec[0]),
    .d1_i      (dec[1]),
    .rd0_i     (rd[0]),
    .rsa0_i    (rsa[0]),
    .rsb0_i    (rsb[0]),
    .rd1_i     (rd[1]),
    .pair_ok_o (pair_ok)
  );

  issue_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (pair_vld_i),
    .rdy0_i    (rdy0_i),
    .rdy1_i    (rdy1_i),
    .pair_ok_i (pair_ok),
    .iss0_o    (issue0_o),
    .iss1_o    (issue1_o),
    .accept_o  (accept_o),
    .hold_o    (hold_o)
  );

endmodule

// File: rtl/dual_issue_pairer_chk.sv
module dual_issue_pairer_chk (
  input logic clk,
  input logic rst,
  input logic pair_vld_i,
  input logic rdy0_i,
  input logic rdy1_i,
  input logic issue0_o,
  input logic issue1_o,
  input logic accept_o,
  input logic hold_o
);

  // Independent record of an older slot that left without its partner.
  logic owed;

  always_ff @(posedge clk) begin
    if (rst) owed <= 1'b0;
    else if (issue1_o) owed <= 1'b0;
    else if (issue0_o) owed <= 1'b1;
  end

  AST_NOT_READY_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !rdy0_i |-> !issue0_o); // R2

  AST_YOUNGER_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    issue1_o |-> (issue0_o || owed)); // R3

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    owed |-> !issue0_o); // R4

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (owed && pair_vld_i && !rdy1_i) |-> hold_o); // R4

  AST_ACCEPT_NEEDS_YOUNGER: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> (issue1_o && !hold_o)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pair_vld_i |-> (!issue0_o && !issue1_o && !accept_o && !hold_o)); // R11

  AST_IDLE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (owed && !pair_vld_i) |=> owed); // R11

endmodule

bind dual_issue_pairer dual_issue_pairer_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .pair_vld_i (pair_vld_i),
  .rdy0_i     (rdy0_i),
  .rdy1_i     (rdy1_i),
  .issue0_o   (issue0_o),
  .issue1_o   (issue1_o),
  .accept_o   (accept_o),
  .hold_o     (hold_o)
);

// File: tb/dual_issue_pairer_tb_top.sv
module dual_issue_pairer_tb_top;

  localparam int REG_W  = 5;
  localparam int DESC_W = 7 + 3 * REG_W;
  localparam int WD_CYC = 5000;

  // Class codes (R6).
  localparam logic [2:0] IOP = 3'd0, FOP = 3'd1, LD = 3'd2, ST = 3'd3, BR = 3'd4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pair_vld_i = 1'b0;
  logic [DESC_W-1:0] desc0_i = '0;
  logic [DESC_W-1:0] desc1_i = '0;
  logic              rdy0_i = 1'b0;
  logic              rdy1_i = 1'b0;
  logic              issue0_o, issue1_o, accept_o, hold_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  dual_issue_pairer #(.REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .pair_vld_i(pair_vld_i),
    .desc0_i(desc0_i), .desc1_i(desc1_i),
    .rdy0_i(rdy0_i), .rdy1_i(rdy1_i),
    .issue0_o(issue0_o), .issue1_o(issue1_o),
    .accept_o(accept_o), .hold_o(hold_o)
  );

  // Pack a descriptor (R6 layout).
  function automatic logic [DESC_W-1:0] mk(input logic [2:0] cls, input logic fp,
      input logic uc, input logic jmp, input logic wr, input int rd,
      input int ra, input int rb);
    logic [REG_W-1:0] d, a, b;
    d = REG_W'(rd); a = REG_W'(ra); b = REG_W'(rb);
    return {b, a, d, wr, jmp, uc, fp, cls};
  endfunction

  // Driver: apply one vector after a rising edge, queue expected {iss0,iss1,acc,hold}.
  task automatic step(input logic r, input logic v, input logic [DESC_W-1:0] a,
      input logic [DESC_W-1:0] b, input logic r0, input logic r1,
      input logic [3:0] exp, input string tag);
    @(posedge clk);
    #2;
    rst = r; pair_vld_i = v; desc0_i = a; desc1_i = b; rdy0_i = r0; rdy1_i = r1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [3:0] e;
        logic [3:0] got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {issue0_o, issue1_o, accept_o, hold_o};
        n_vec++;
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: got iss0/iss1/acc/hold=%b expected %b", t, got, e);
        end
      end
    end
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < WD_CYC && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion expected completion within %0d cycles", WD_CYC);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DESC_W-1:0] iop_a, iop_b, fop_a, fop_b, ld_i, st_i, st_f, br_i, br_f;
    iop_a = mk(IOP, 0, 0, 0, 1, 1, 2, 3);
    iop_b = mk(IOP, 0, 0, 0, 1, 4, 5, 6);
    fop_a = mk(FOP, 1, 0, 0, 1, 8, 9, 10);
    fop_b = mk(FOP, 1, 0, 0, 1, 11, 12, 13);
    ld_i  = mk(LD, 0, 0, 0, 1, 14, 15, 0);
    st_i  = mk(ST, 0, 0, 0, 0, 0, 16, 17);
    st_f  = mk(ST, 1, 0, 0, 0, 0, 18, 19);
    br_i  = mk(BR, 0, 0, 0, 0, 0, 20, 0);
    br_f  = mk(BR, 1, 0, 0, 0, 0, 21, 0);

    // R1: reset forces quiet outputs even with a ready pair.
    step(1, 1, iop_a, fop_a, 1, 1, 4'b0000, "R1 reset quiet");
    step(1, 1, iop_a, fop_a, 1, 0, 4'b0000, "R1 reset quiet single");
    // R8 / R2
    step(0, 1, iop_a, fop_a, 1, 1, 4'b1110, "R8 iop+fop");
    step(0, 1, fop_a, iop_a, 1, 1, 4'b1110, "R8 fop+iop");
    // R7
    step(0, 1, ld_i, fop_a, 1, 1, 4'b1110, "R7 load+fop");
    step(0, 1, ld_i, iop_a, 1, 1, 4'b1110, "R7 load+iop");
    step(0, 1, st_i, iop_b, 1, 1, 4'b1110, "R7 int store+iop");
    step(0, 1, st_f, fop_a, 1, 1, 4'b1110, "R7 fp store+fop");
    step(0, 1, st_i, fop_a, 1, 1, 4'b1001, "R7 int store+fop split");
    step(0, 1, st_i, fop_a, 1, 1, 4'b0110, "R4 younger alone");
    step(0, 1, iop_a, st_f, 1, 1, 4'b1001, "R7 iop+fp store split");
    step(0, 1, iop_a, st_f, 1, 0, 4'b0001, "R4 younger not ready");
    step(0, 1, iop_a, st_f, 1, 0, 4'b0001, "R4 still waiting");
    step(0, 1, iop_a, st_f, 1, 1, 4'b0110, "R4 younger goes");
    // R6
    step(0, 1, ld_i, st_i, 1, 1, 4'b1001, "R6 two memory");
    step(0, 1, ld_i, st_i, 1, 1, 4'b0110, "R6 second memory alone");
    step(0, 1, fop_a, fop_b, 1, 1, 4'b1001, "R6 two fops");
    step(0, 1, fop_a, fop_b, 1, 1, 4'b0110, "R6 second fop alone");
    step(0, 1, mk(3'd5, 0, 0, 0, 0, 0, 0, 0), fop_a, 1, 1, 4'b1001, "R6 undefined class");
    step(0, 1, mk(3'd5, 0, 0, 0, 0, 0, 0, 0), fop_a, 1, 1, 4'b0110, "R6 undefined drains");
    // R9
    step(0, 1, br_i, st_i, 1, 1, 4'b1001, "R9 branch+same-format store");
    step(0, 1, br_i, st_i, 1, 1, 4'b0110, "R9 store alone");
    step(0, 1, st_f, br_f, 1, 1, 4'b1001, "R9 fp store+fp branch");
    step(0, 1, st_f, br_f, 1, 1, 4'b0110, "R9 branch alone");
    step(0, 1, br_f, st_i, 1, 1, 4'b1110, "R9 branch+other-format store");
    step(0, 1, br_i, ld_i, 1, 1, 4'b1110, "R9 branch+load");
    step(0, 1, br_i, fop_a, 1, 1, 4'b1110, "R9 branch+fop");
    // R10
    step(0, 1, iop_a, iop_b, 1, 1, 4'b1110, "R10 two simple iops");
    step(0, 1, mk(IOP, 0, 1, 0, 1, 1, 2, 3), iop_b, 1, 1, 4'b1001, "R10 older microcoded");
    step(0, 1, mk(IOP, 0, 1, 0, 1, 1, 2, 3), iop_b, 1, 1, 4'b0110, "R10 drain");
    step(0, 1, iop_a, mk(IOP, 0, 1, 0, 1, 4, 5, 6), 1, 1, 4'b1001, "R10 younger microcoded");
    step(0, 1, iop_a, mk(IOP, 0, 1, 0, 1, 4, 5, 6), 1, 1, 4'b0110, "R10 drain");
    step(0, 1, mk(BR, 0, 0, 1, 0, 0, 20, 0), iop_b, 1, 1, 4'b1001, "R10 older jump");
    step(0, 1, mk(BR, 0, 0, 1, 0, 0, 20, 0), iop_b, 1, 1, 4'b0110, "R10 drain");
    step(0, 1, iop_a, mk(BR, 0, 0, 1, 0, 0, 20, 0), 1, 1, 4'b1110, "R10 younger jump pairs");
    step(0, 1, iop_a, mk(IOP, 0, 0, 0, 1, 3, 5, 6), 1, 1, 4'b1001, "R10 WAR");
    step(0, 1, iop_a, mk(IOP, 0, 0, 0, 1, 3, 5, 6), 1, 1, 4'b0110, "R10 drain");
    step(0, 1, iop_a, mk(IOP, 0, 0, 0, 1, 1, 5, 6), 1, 1, 4'b1001, "R10 WAW");
    step(0, 1, iop_a, mk(IOP, 0, 0, 0, 1, 1, 5, 6), 1, 1, 4'b0110, "R10 drain");
    step(0, 1, iop_a, mk(IOP, 0, 0, 0, 1, 7, 1, 1), 1, 1, 4'b1110, "R10 RAW still pairs");
    // R2 / R3
    step(0, 1, iop_a, fop_a, 0, 1, 4'b0001, "R3 older stalls younger");
    step(0, 1, iop_a, fop_a, 0, 0, 4'b0001, "R2 neither ready");
    step(0, 1, iop_a, fop_a, 1, 0, 4'b1001, "R2 older alone");
    step(0, 1, iop_a, fop_a, 1, 1, 4'b0110, "R4 no reissue");
    // R11
    step(0, 0, iop_a, fop_a, 1, 1, 4'b0000, "R11 empty buffer");
    step(0, 1, iop_a, st_f, 1, 0, 4'b1001, "R11 set pending");
    step(0, 0, iop_a, st_f, 1, 1, 4'b0000, "R11 empty while pending");
    step(0, 1, iop_a, st_f, 1, 1, 4'b0110, "R11 pending kept");
    // R1: reset clears a pending pair.
    step(0, 1, iop_a, st_f, 1, 0, 4'b1001, "R1 set pending");
    step(1, 1, iop_a, st_f, 1, 1, 4'b0000, "R1 reset quiet pending");
    step(0, 1, iop_a, fop_a, 1, 1, 4'b1110, "R1 fresh after reset");
    step(0, 0, iop_a, fop_a, 0, 0, 4'b0000, "R11 final idle");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule